// File: doc/BRIEF.md
# Temperature Sensor Register Bank with Atomic Read Latch

This block is the byte-wide register file that sits behind a two-wire management target on a die temperature sensor. It holds the live temperature and two programmable limits, a high one and a low one. Each value is 11 bits wide in 0.125-degree steps, which covers 0 to 255.875 degrees. Software sees each value as an integer byte and a fraction byte. The fraction byte carries its three fractional bits at the top, and its low five bits are always zero. For example, an integer byte of 0x19 with a fraction byte of 0x20 reads as 25.125 degrees.

The temperature takes two single-byte reads, so a new sample could land between them. To prevent this, the first read of the pair copies the matching other half into a snapshot, and the second read returns that copy. A strap input fixes which half counts as first, and the configuration register reflects that strap. The block compares the live temperature with both limits continuously. It shows the result as two status bits and as one alert output.

The register port takes one access per cycle. Read data is registered: it appears on the clock edge that samples the read strobe and holds until the next read.

Top module: `tsense_regbank`

## Requirements
- R1: After reset, the temperature reads 0x00/0x00, the high limit reads 0x46 integer and 0x00 fraction (70.000 degrees), the low limit reads 0x00/0x00, and `alert` is 1 because 0 is less than or equal to the low limit.
- R2: `reg_rdata` takes the addressed value at the clock edge where `reg_rd` is 1 and keeps that value through cycles without a read, even when samples arrive.
- R3: The fraction registers (0x10, 0x13 and 0x14) return the fraction in bits 7:5 with bits 4:0 as zero. A write to 0x13 or 0x14 stores only write-data bits 7:5.
- R4: Each cycle with `samp_valid` high loads `samp_temp` into the live temperature. `samp_temp[10:3]` is the integer byte at address 0x01, and `samp_temp[2:0]` becomes bits 7:5 of the fraction byte at address 0x10.
- R5: With `order_strap` at 0, a read of 0x01 copies the live fraction into the snapshot. The next read of 0x10 returns that copy and releases it. A read of 0x10 with no copy pending returns the live fraction.
- R6: With `order_strap` at 1, a read of 0x10 copies the live integer byte into the snapshot. The next read of 0x01 returns that copy and releases it. A read of 0x01 with no copy pending returns the live integer.
- R7: The configuration register (0x03) returns `order_strap` in bit 5, and its other bits are zero.
- R8: In the status register (0x02), bit 4 is 1 when temperature is greater than or equal to the high limit, bit 3 is 1 when temperature is less than or equal to the low limit, and all other bits are 0. All three values are compared as 11-bit numbers.
- R9: `alert` is the OR of the two status conditions and follows the live temperature and limits with no read needed.
- R10: Writes to 0x01, 0x02, 0x03, 0x10 and to unmapped addresses change nothing. Reads of unmapped addresses return 0x00.
- R11: The limit integer bytes (0x07 high, 0x08 low) and the limit fraction bytes (0x13 high, 0x14 low) read back what was written, within the rule of R3.
- R12: When a sample arrives in the same cycle as a first-half read, both halves of the pair come from the value held before that sample. The next pair then shows the new sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register address for the current access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| samp_valid | input | 1 | New sensor sample strobe |
| samp_temp | input | 11 | Sensor sample, in units of 0.125 degree |
| order_strap | input | 1 | Static read-order select: 0 means integer first, 1 means fraction first |
| alert | output | 1 | Limit alert, high or low |

## Verification
Two functions can land in the same cycle: a new sensor sample arriving and the first-half read that arms the snapshot. The bench provokes this by raising `samp_valid` and `reg_rd` at address 0x01 on the same clock edge. It then reads the fraction, and afterwards the pair again. The expected result is that the first pair belongs entirely to the old sample and the second pair entirely to the new one. A sample between the two reads of a pair is also checked under both strap settings, and must never mix into the returned pair.

// File: rtl/tsense_pkg.sv
// Shared widths, register offsets and bit positions for the temperature
// register bank. Offsets are fixed because host software decodes them.
package tsense_pkg;
    localparam int BYTE_W  = 8;
    localparam int FRAC_W  = 3;
    localparam int TEMP_W  = BYTE_W + FRAC_W;
    localparam int PAD_W   = BYTE_W - FRAC_W;

    localparam logic [BYTE_W-1:0] A_TEMP_INT = 8'h01;
    localparam logic [BYTE_W-1:0] A_STATUS   = 8'h02;
    localparam logic [BYTE_W-1:0] A_CONFIG   = 8'h03;
    localparam logic [BYTE_W-1:0] A_HI_INT   = 8'h07;
    localparam logic [BYTE_W-1:0] A_LO_INT   = 8'h08;
    localparam logic [BYTE_W-1:0] A_TEMP_FRC = 8'h10;
    localparam logic [BYTE_W-1:0] A_HI_FRC   = 8'h13;
    localparam logic [BYTE_W-1:0] A_LO_FRC   = 8'h14;

    localparam int CFG_ORDER_BIT = 5;
    localparam int STS_HI_BIT    = 4;
    localparam int STS_LO_BIT    = 3;
endpackage

// File: rtl/tsense_limit.sv
// One programmable limit (11-bit, 0.125 degree steps).
// Assumes the caller decodes separate integer and fraction write strobes;
// a fraction write keeps only the top FRAC_W data bits.
module tsense_limit
    import tsense_pkg::*;
#(
    parameter logic [TEMP_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_int,
    input  logic              wr_frac,
    input  logic [BYTE_W-1:0] wdata,
    output logic [TEMP_W-1:0] value
);
    // Holds the limit; integer and fraction halves written independently.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= RESET_VAL;
        end else begin
            if (wr_int)
                value[TEMP_W-1:FRAC_W] <= wdata;
            if (wr_frac)
                value[FRAC_W-1:0] <= wdata[BYTE_W-1:PAD_W];
        end
    end
endmodule

// File: rtl/tsense_snapshot.sv
// Atomic two-byte read helper. The half selected as "first" by the order
// input copies the other half into a snapshot; the next read of that other
// half returns the copy and clears it. Assumes order is static.
module tsense_snapshot
    import tsense_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              order,
    input  logic              rd_int,
    input  logic              rd_frac,
    input  logic [TEMP_W-1:0] live,
    output logic [BYTE_W-1:0] int_view,
    output logic [BYTE_W-1:0] frac_view
);
    logic [BYTE_W-1:0] snap;
    logic              pending;
    logic [BYTE_W-1:0] live_int;
    logic [BYTE_W-1:0] live_frac;
    logic              first_rd;
    logic              second_rd;

    // Split the live value into its two register bytes.
    always_comb begin
        live_int  = live[TEMP_W-1:FRAC_W];
        live_frac = {live[FRAC_W-1:0], {PAD_W{1'b0}}};
        first_rd  = order ? rd_frac : rd_int;
        second_rd = order ? rd_int  : rd_frac;
    end

    // Arm the snapshot on the first half, release it on the second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap    <= '0;
            pending <= 1'b0;
        end else if (first_rd) begin
            snap    <= order ? live_int : live_frac;
            pending <= 1'b1;
        end else if (second_rd) begin
            pending <= 1'b0;
        end
    end

    // Present the snapshot in place of the second half while armed.
    always_comb begin
        int_view  = (order  && pending) ? snap : live_int;
        frac_view = (!order && pending) ? snap : live_frac;
    end
endmodule

// File: rtl/tsense_compare.sv
// Limit comparator: high flag at or above the high limit, low flag at or
// below the low limit. Purely combinational; inputs are registered upstream.
module tsense_compare
    import tsense_pkg::*;
(
    input  logic [TEMP_W-1:0] temp,
    input  logic [TEMP_W-1:0] hi_lim,
    input  logic [TEMP_W-1:0] lo_lim,
    output logic              hi_flag,
    output logic              lo_flag
);
    // Unsigned 11-bit comparisons against both limits.
    always_comb begin
        hi_flag = (temp >= hi_lim);
        lo_flag = (temp <= lo_lim);
    end
endmodule

// File: rtl/tsense_regbank.sv
// Temperature register bank: live temperature, two limits, status, config.
// Assumes one register access per cycle and a static order_strap.
// Read data is registered and holds between reads.
module tsense_regbank
    import tsense_pkg::*;
#(
    parameter logic [TEMP_W-1:0] HI_RESET = 11'd560,
    parameter logic [TEMP_W-1:0] LO_RESET = 11'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic              reg_rd,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              samp_valid,
    input  logic [TEMP_W-1:0] samp_temp,
    input  logic              order_strap,
    output logic              alert
);
    logic [TEMP_W-1:0] temp_q;
    logic [TEMP_W-1:0] hi_lim;
    logic [TEMP_W-1:0] lo_lim;
    logic              hi_flag;
    logic              lo_flag;
    logic [BYTE_W-1:0] int_view;
    logic [BYTE_W-1:0] frac_view;
    logic [BYTE_W-1:0] rd_next;
    logic [BYTE_W-1:0] status_b;
    logic [BYTE_W-1:0] config_b;
    logic              rd_int;
    logic              rd_frac;

    // Live temperature follows each valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            temp_q <= '0;
        else if (samp_valid)
            temp_q <= samp_temp;
    end

    // Read strobes for the two temperature halves.
    always_comb begin
        rd_int  = reg_rd && (reg_addr == A_TEMP_INT);
        rd_frac = reg_rd && (reg_addr == A_TEMP_FRC);
    end

    tsense_snapshot u_snap (
        .clk       (clk),
        .rst_n     (rst_n),
        .order     (order_strap),
        .rd_int    (rd_int),
        .rd_frac   (rd_frac),
        .live      (temp_q),
        .int_view  (int_view),
        .frac_view (frac_view)
    );

    tsense_limit #(.RESET_VAL(HI_RESET)) u_hi (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_int  (reg_wr && (reg_addr == A_HI_INT)),
        .wr_frac (reg_wr && (reg_addr == A_HI_FRC)),
        .wdata   (reg_wdata),
        .value   (hi_lim)
    );

    tsense_limit #(.RESET_VAL(LO_RESET)) u_lo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_int  (reg_wr && (reg_addr == A_LO_INT)),
        .wr_frac (reg_wr && (reg_addr == A_LO_FRC)),
        .wdata   (reg_wdata),
        .value   (lo_lim)
    );

    tsense_compare u_cmp (
        .temp    (temp_q),
        .hi_lim  (hi_lim),
        .lo_lim  (lo_lim),
        .hi_flag (hi_flag),
        .lo_flag (lo_flag)
    );

    // Build status and configuration bytes.
    always_comb begin
        status_b = '0;
        status_b[STS_HI_BIT] = hi_flag;
        status_b[STS_LO_BIT] = lo_flag;
        config_b = '0;
        config_b[CFG_ORDER_BIT] = order_strap;
    end

    // Address decode for read data; unmapped addresses give zero.
    always_comb begin
        case (reg_addr)
            A_TEMP_INT: rd_next = int_view;
            A_STATUS:   rd_next = status_b;
            A_CONFIG:   rd_next = config_b;
            A_HI_INT:   rd_next = hi_lim[TEMP_W-1:FRAC_W];
            A_LO_INT:   rd_next = lo_lim[TEMP_W-1:FRAC_W];
            A_TEMP_FRC: rd_next = frac_view;
            A_HI_FRC:   rd_next = {hi_lim[FRAC_W-1:0], {PAD_W{1'b0}}};
            A_LO_FRC:   rd_next = {lo_lim[FRAC_W-1:0], {PAD_W{1'b0}}};
            default:    rd_next = '0;
        endcase
    end

    // Register read data on each read strobe; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_rd)
            reg_rdata <= rd_next;
    end

    // Alert raised by either limit condition.
    always_comb alert = hi_flag | lo_flag;
endmodule

// File: rtl/tsense_regbank_chk.sv
// Property checker for tsense_regbank, attached by bind below.
module tsense_regbank_chk
    import tsense_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [BYTE_W-1:0] reg_addr,
    input logic              reg_rd,
    input logic [BYTE_W-1:0] reg_rdata,
    input logic              order_strap,
    input logic              alert,
    input logic [TEMP_W-1:0] temp_q,
    input logic [TEMP_W-1:0] hi_lim,
    input logic [TEMP_W-1:0] lo_lim
);
    logic mapped;
    logic frac_addr;

    // Classify the current address.
    always_comb begin
        mapped = (reg_addr == A_TEMP_INT) || (reg_addr == A_STATUS) ||
                 (reg_addr == A_CONFIG)   || (reg_addr == A_HI_INT) ||
                 (reg_addr == A_LO_INT)   || (reg_addr == A_TEMP_FRC) ||
                 (reg_addr == A_HI_FRC)   || (reg_addr == A_LO_FRC);
        frac_addr = (reg_addr == A_TEMP_FRC) || (reg_addr == A_HI_FRC) ||
                    (reg_addr == A_LO_FRC);
    end

    assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

    assert_frac_low_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && frac_addr) |=> (reg_rdata[PAD_W-1:0] == '0));

    assert_cfg_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_CONFIG) |=>
            (reg_rdata == ($past(order_strap) ? 8'h20 : 8'h00)));

    assert_status_spare_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_STATUS) |=>
            (reg_rdata[7:5] == 3'b0 && reg_rdata[2:0] == 3'b0));

    assert_alert_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        alert == ((temp_q >= hi_lim) || (temp_q <= lo_lim)));

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !mapped) |=> (reg_rdata == '0));
endmodule

bind tsense_regbank tsense_regbank_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .reg_rd      (reg_rd),
    .reg_rdata   (reg_rdata),
    .order_strap (order_strap),
    .alert       (alert),
    .temp_q      (temp_q),
    .hi_lim      (hi_lim),
    .lo_lim      (lo_lim)
);

// File: tb/test_tsense_regbank.sv
module test_tsense_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_rdata;
    logic        samp_valid = 1'b0;
    logic [10:0] samp_temp = '0;
    logic        order_strap = 1'b0;
    logic        alert;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tsense_regbank i_tsense_regbank (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .samp_valid(samp_valid), .samp_temp(samp_temp),
        .order_strap(order_strap), .alert(alert)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ibyte(input logic [10:0] t);
        return t[10:3];
    endfunction
    function automatic logic [7:0] fbyte(input logic [10:0] t);
        return {t[2:0], 5'b0};
    endfunction

    task automatic do_reset(input logic ord);
        @(negedge clk);
        order_strap = ord;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(posedge clk);
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic sample(input logic [10:0] t);
        @(negedge clk);
        samp_temp = t; samp_valid = 1'b1;
        @(negedge clk);
        samp_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        do_reset(1'b0);
        check("R1 alert", {7'b0, alert}, 8'h01);
        rd(8'h01, d); check("R1 temp int", d, 8'h00);
        rd(8'h10, d); check("R1 temp frac", d, 8'h00);
        rd(8'h07, d); check("R1 hi int", d, 8'h46);
        rd(8'h13, d); check("R1 hi frac", d, 8'h00);
        rd(8'h08, d); check("R1 lo int", d, 8'h00);
        rd(8'h14, d); check("R1 lo frac", d, 8'h00);
        rd(8'h03, d); check("R7 config order0", d, 8'h00);
    endtask

    task automatic t_order0;
        logic [7:0] d;
        logic [10:0] a = 11'd201;
        logic [10:0] b = 11'h1FF;
        sample(a);
        rd(8'h01, d); check("R4 int 25.125", d, 8'h19);
        rd(8'h10, d); check("R4 R3 frac 25.125", d, 8'h20);
        rd(8'h01, d); check("R5 first half", d, ibyte(a));
        sample(b);
        rd(8'h10, d); check("R5 snapshot frac", d, fbyte(a));
        rd(8'h10, d); check("R5 live frac after release", d, fbyte(b));
        rd(8'h01, d); check("R4 live int", d, ibyte(b));
        // R2: hold across idle cycles and a new sample
        sample(11'd5);
        repeat (3) @(negedge clk);
        check("R2 rdata held", reg_rdata, ibyte(b));
        rd(8'h10, d); check("R5 second of pair", d, fbyte(b));
    endtask

    task automatic t_order1;
        logic [7:0] d;
        logic [10:0] a = 11'd201;
        logic [10:0] b = 11'd1023;
        do_reset(1'b1);
        rd(8'h03, d); check("R7 config order1", d, 8'h20);
        sample(a);
        rd(8'h10, d); check("R6 first half frac", d, fbyte(a));
        sample(b);
        rd(8'h01, d); check("R6 snapshot int", d, ibyte(a));
        rd(8'h01, d); check("R6 live int after release", d, ibyte(b));
        rd(8'h10, d); check("R6 frac new pair", d, fbyte(b));
        rd(8'h01, d); check("R6 int new pair", d, ibyte(b));
    endtask

    task automatic t_limits;
        logic [7:0] d;
        do_reset(1'b0);
        wr(8'h07, 8'h50); wr(8'h13, 8'hFF);
        wr(8'h08, 8'h10); wr(8'h14, 8'h5F);
        rd(8'h07, d); check("R11 hi int", d, 8'h50);
        rd(8'h13, d); check("R3 R11 hi frac", d, 8'hE0);
        rd(8'h08, d); check("R11 lo int", d, 8'h10);
        rd(8'h14, d); check("R3 R11 lo frac", d, 8'h40);
    endtask

    task automatic t_compare;
        logic [7:0] d;
        // hi = 0x50.E0 = 647, lo = 0x10.40 = 130 (from t_limits)
        sample(11'd646);
        rd(8'h02, d); check("R8 between", d, 8'h00);
        check("R9 alert between", {7'b0, alert}, 8'h00);
        sample(11'd647);
        rd(8'h02, d); check("R8 at high", d, 8'h10);
        check("R9 alert at high", {7'b0, alert}, 8'h01);
        sample(11'd130);
        rd(8'h02, d); check("R8 at low", d, 8'h08);
        check("R9 alert at low", {7'b0, alert}, 8'h01);
        sample(11'd131);
        rd(8'h02, d); check("R8 above low", d, 8'h00);
        wr(8'h14, 8'h60);  // lo = 131
        check("R9 alert after limit write", {7'b0, alert}, 8'h01);
        rd(8'h02, d); check("R8 both flags", d, 8'h08);
    endtask

    task automatic t_ignore;
        logic [7:0] d;
        do_reset(1'b0);
        sample(11'd300);
        wr(8'h01, 8'hAA); wr(8'h10, 8'hE0); wr(8'h02, 8'hFF);
        wr(8'h03, 8'hFF); wr(8'h55, 8'h33); wr(8'h00, 8'h01);
        rd(8'h01, d); check("R10 temp int unchanged", d, ibyte(11'd300));
        rd(8'h10, d); check("R10 temp frac unchanged", d, fbyte(11'd300));
        rd(8'h03, d); check("R10 config unchanged", d, 8'h00);
        rd(8'h07, d); check("R10 hi unchanged", d, 8'h46);
        rd(8'h08, d); check("R10 lo unchanged", d, 8'h00);
        rd(8'h55, d); check("R10 unmapped read", d, 8'h00);
        rd(8'h13, d); check("R10 hi frac unchanged", d, 8'h00);
    endtask

    task automatic t_same_cycle;
        logic [7:0] d;
        logic [10:0] a = 11'd300;
        logic [10:0] b = 11'd501;
        do_reset(1'b0);
        sample(a);
        @(negedge clk);
        reg_addr = 8'h01; reg_rd = 1'b1;
        samp_temp = b; samp_valid = 1'b1;
        @(posedge clk);
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; samp_valid = 1'b0;
        check("R12 int from old sample", d, ibyte(a));
        rd(8'h10, d); check("R12 frac from old sample", d, fbyte(a));
        rd(8'h01, d); check("R12 next int new", d, ibyte(b));
        rd(8'h10, d); check("R12 next frac new", d, fbyte(b));
    endtask

    initial begin
        t_reset;
        t_order0;
        t_order1;
        t_limits;
        t_compare;
        t_ignore;
        t_same_cycle;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule